// File: doc/BRIEF.md
# Issue-Activity Supply Scaling Controller

This block decides, around second-level cache misses, when a core may drop to a low supply point and when it must return. It watches three inputs: a one-cycle pulse when a miss leaves for memory, a one-cycle pulse when a miss comes back, and the number of instructions issued in the current cycle. It keeps a saturating count of misses in flight. Two separate state machines act on these inputs. One lowers the supply. The other raises it.

To lower the supply, a miss arms a window ten cycles long. If the core issues nothing for three cycles in a row inside that window, the block asserts the low-supply request. To raise the supply, the return of the last outstanding miss releases the request at once. A return that still leaves other misses in flight instead arms a ten-cycle window. In that window the request is released once three cycles, not necessarily adjacent, have issued at least one instruction. A window that closes without meeting its condition leaves the supply as it was and sends its machine back to idle. The regulator that carries out these requests is outside this block.

Top module: `issue_supply_ctrl`

## Requirements
- R1: The in-flight miss count goes up by one on a miss pulse and down by one on a return pulse. It saturates at 15 and at 0. When both pulses arrive in the same cycle, the count does not change.
- R2: While `low_req` is 0, a miss pulse arms a down window made of the 10 cycles that follow the miss cycle. If `issue_cnt` is 0 in 3 consecutive window cycles, `low_req` rises at the edge that samples the third such cycle, and `drop_evt` is 1 for exactly that one cycle.
- R3: A down window that ends without such a run leaves `low_req` at 0. Idle cycles after the window do not lower the supply until another miss pulse arrives.
- R4: A window cycle with nonzero `issue_cnt` resets the run of idle cycles. The miss cycle itself never counts toward the run.
- R5: While `low_req` is 1, a return pulse that arrives with a count of 1 and no miss pulse in the same cycle clears `low_req` at that edge. `raise_evt` is 1 for exactly that cycle.
- R6: While `low_req` is 1, any other return pulse arms an up window made of the 10 following cycles. This includes a return with a count above 1 and a return that coincides with a miss. `low_req` clears, with a `raise_evt` pulse, at the edge that samples the third window cycle with nonzero `issue_cnt`.
- R7: An up window that ends with fewer than 3 active cycles leaves `low_req` at 1. Later active cycles do not change it until another return pulse arrives.
- R8: A miss pulse while `low_req` is 1 arms no down window and produces no `drop_evt`, but it still adds to the count.
- R9: During a down window, a return pulse that empties the count cancels the window. No drop follows from that window.
- R10: A return pulse while `low_req` is 0 produces no `raise_evt`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| miss_pulse | input | 1 | One-cycle pulse: an L2 miss was issued to memory |
| ret_pulse | input | 1 | One-cycle pulse: an L2 miss returned |
| issue_cnt | input | ISSUE_W (3) | Instructions issued this cycle |
| low_req | output | 1 | Level: request the low supply point |
| drop_evt | output | 1 | One-cycle pulse as `low_req` rises |
| raise_evt | output | 1 | One-cycle pulse as `low_req` falls |

## Verification
A miss pulse and a return pulse can arrive in the same cycle. That single edge then reaches both the saturating counter and the raise decision. The bench provokes this with the supply low and exactly one miss in flight. The count must hold at 1, so the return must not be taken as the last one. The result is judged at the ports: `low_req` must stay high until three active cycles have passed, and then a later lone return must release nothing. Counter saturation is also judged at the ports: after sixteen extra misses, exactly the fifteenth return must release the supply.

// File: rtl/supply_scale_pkg.sv
// Package: types shared by the supply scaling controller.
// Assumes: both observation machines use the same two-state encoding.
package supply_scale_pkg;
    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_WATCH = 1'b1
    } watch_st_t;
endpackage

// File: rtl/miss_tracker.sv
// Saturating count of second-level misses in flight.
// Assumes: miss and return pulses last one cycle each; when both arrive
// in the same cycle they cancel out.
module miss_tracker #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             miss_i,
    input  logic             ret_i,
    output logic [CNT_W-1:0] cnt_o,
    output logic             cnt_one_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q;

    // Step the count up or down with saturation at both ends.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (miss_i && !ret_i) begin
            if (cnt_q != CNT_MAX) cnt_q <= cnt_q + CNT_ONE;
        end else if (ret_i && !miss_i) begin
            if (cnt_q != '0) cnt_q <= cnt_q - CNT_ONE;
        end
    end

    assign cnt_o     = cnt_q;
    assign cnt_one_o = (cnt_q == CNT_ONE);

    // R1
    both_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_i && ret_i) |=> $stable(cnt_q));
    // R1
    floor_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_i && !miss_i && cnt_q == '0) |=> (cnt_q == '0));
    // R1
    ceil_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (miss_i && !ret_i && cnt_q == CNT_MAX) |=> (cnt_q == CNT_MAX));
endmodule

// File: rtl/down_watch.sv
// Scale-down machine: after a miss taken at full supply, it watches the
// next WIN_LEN cycles and fires once DOWN_RUN consecutive cycles issue
// nothing.
// Assumes: low_i is the registered supply request; last_ret_i marks a
// return that empties the in-flight count.
module down_watch
    import supply_scale_pkg::*;
#(
    parameter int WIN_LEN  = 10,
    parameter int DOWN_RUN = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic miss_i,
    input  logic last_ret_i,
    input  logic low_i,
    input  logic idle_i,
    output logic fire_o
);
    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int RUN_W = $clog2(DOWN_RUN + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic [RUN_W-1:0] RUN_GOAL = RUN_W'(DOWN_RUN);

    watch_st_t        st_q, st_d;
    logic [WIN_W-1:0] win_q, win_d;
    logic [RUN_W-1:0] run_q, run_d, run_n;

    // Next-state decision for the idle-run window.
    always_comb begin
        st_d   = st_q;
        win_d  = win_q;
        run_d  = run_q;
        fire_o = 1'b0;
        run_n  = idle_i ? (run_q + RUN_W'(1)) : '0;
        case (st_q)
            ST_IDLE: begin
                if (miss_i && !low_i) begin
                    st_d  = ST_WATCH;
                    win_d = '0;
                    run_d = '0;
                end
            end
            ST_WATCH: begin
                if (last_ret_i) begin
                    st_d = ST_IDLE;
                end else if (run_n >= RUN_GOAL) begin
                    fire_o = 1'b1;
                    st_d   = ST_IDLE;
                end else if (win_q == WIN_LAST) begin
                    st_d = ST_IDLE;
                end else begin
                    win_d = win_q + WIN_W'(1);
                    run_d = run_n;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Hold the machine state and window counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
            run_q <= '0;
        end else begin
            st_q  <= st_d;
            win_q <= win_d;
            run_q <= run_d;
        end
    end

    // R2
    dwin_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WATCH) |-> !low_i);
    // R9
    dwin_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WATCH && last_ret_i) |-> !fire_o);
    // R3
    dwin_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WATCH) |-> (win_q <= WIN_LAST));
endmodule

// File: rtl/up_watch.sv
// Scale-up machine: a return that empties the in-flight count raises the
// supply at once; any other return while low opens a WIN_LEN window that
// raises once UP_HITS cycles have issued something.
// Assumes: low_i is the registered supply request.
module up_watch
    import supply_scale_pkg::*;
#(
    parameter int WIN_LEN = 10,
    parameter int UP_HITS = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ret_i,
    input  logic last_ret_i,
    input  logic low_i,
    input  logic active_i,
    output logic fire_o
);
    localparam int WIN_W = (WIN_LEN > 1) ? $clog2(WIN_LEN) : 1;
    localparam int HIT_W = $clog2(UP_HITS + 1);
    localparam logic [WIN_W-1:0] WIN_LAST = WIN_W'(WIN_LEN - 1);
    localparam logic [HIT_W-1:0] HIT_GOAL = HIT_W'(UP_HITS);

    watch_st_t        st_q, st_d;
    logic [WIN_W-1:0] win_q, win_d;
    logic [HIT_W-1:0] hit_q, hit_d, hit_n;

    // Next-state decision for immediate and windowed raises.
    always_comb begin
        st_d   = st_q;
        win_d  = win_q;
        hit_d  = hit_q;
        fire_o = 1'b0;
        hit_n  = hit_q + (active_i ? HIT_W'(1) : HIT_W'(0));
        case (st_q)
            ST_IDLE: begin
                if (low_i && last_ret_i) begin
                    fire_o = 1'b1;
                end else if (low_i && ret_i) begin
                    st_d  = ST_WATCH;
                    win_d = '0;
                    hit_d = '0;
                end
            end
            ST_WATCH: begin
                if (last_ret_i || hit_n >= HIT_GOAL) begin
                    fire_o = 1'b1;
                    st_d   = ST_IDLE;
                end else if (win_q == WIN_LAST) begin
                    st_d = ST_IDLE;
                end else begin
                    win_d = win_q + WIN_W'(1);
                    hit_d = hit_n;
                end
            end
            default: st_d = ST_IDLE;
        endcase
    end

    // Hold the machine state and window counters.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ST_IDLE;
            win_q <= '0;
            hit_q <= '0;
        end else begin
            st_q  <= st_d;
            win_q <= win_d;
            hit_q <= hit_d;
        end
    end

    // R6
    uwin_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_WATCH) |-> low_i);
    // R10
    uwin_nofire_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !low_i |-> !fire_o);
endmodule

// File: rtl/issue_supply_ctrl.sv
// Top: combines the miss counter and the two observation machines, and
// registers the low-supply request together with its edge pulses.
// Assumes: inputs are synchronous to clk; issue_cnt is valid every cycle.
module issue_supply_ctrl #(
    parameter int ISSUE_W  = 3,
    parameter int CNT_W    = 4,
    parameter int WIN_LEN  = 10,
    parameter int DOWN_RUN = 3,
    parameter int UP_HITS  = 3
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               miss_pulse,
    input  logic               ret_pulse,
    input  logic [ISSUE_W-1:0] issue_cnt,
    output logic               low_req,
    output logic               drop_evt,
    output logic               raise_evt
);
    logic [CNT_W-1:0] cnt;
    logic             cnt_one;
    logic             last_ret;
    logic             idle_cyc;
    logic             drop_fire;
    logic             raise_fire;
    logic             low_q, drop_q, raise_q;

    assign last_ret = ret_pulse && cnt_one && !miss_pulse;
    assign idle_cyc = (issue_cnt == '0);

    miss_tracker #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .miss_i    (miss_pulse),
        .ret_i     (ret_pulse),
        .cnt_o     (cnt),
        .cnt_one_o (cnt_one)
    );

    down_watch #(.WIN_LEN(WIN_LEN), .DOWN_RUN(DOWN_RUN)) u_down (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_i     (miss_pulse),
        .last_ret_i (last_ret),
        .low_i      (low_q),
        .idle_i     (idle_cyc),
        .fire_o     (drop_fire)
    );

    up_watch #(.WIN_LEN(WIN_LEN), .UP_HITS(UP_HITS)) u_up (
        .clk        (clk),
        .rst_n      (rst_n),
        .ret_i      (ret_pulse),
        .last_ret_i (last_ret),
        .low_i      (low_q),
        .active_i   (!idle_cyc),
        .fire_o     (raise_fire)
    );

    // Register the supply request level and its one-cycle edge pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q   <= 1'b0;
            drop_q  <= 1'b0;
            raise_q <= 1'b0;
        end else begin
            drop_q  <= drop_fire;
            raise_q <= raise_fire;
            if (drop_fire)       low_q <= 1'b1;
            else if (raise_fire) low_q <= 1'b0;
        end
    end

    assign low_req   = low_q;
    assign drop_evt  = drop_q;
    assign raise_evt = raise_q;

    // R2
    rise_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(low_q) |-> drop_q);
    // R5
    fall_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(low_q) |-> raise_q);
    // R8
    low_nodrop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (low_q && miss_pulse) |=> !drop_q);
    // R5
    low_inflight_chk: assert property (@(posedge clk) disable iff (!rst_n)
        low_q |-> (cnt != '0));
    // R2
    excl_evt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(drop_q && raise_q));
endmodule

// File: tb/sim_issue_supply_ctrl.sv
module sim_issue_supply_ctrl;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       miss_pulse = 1'b0;
    logic       ret_pulse = 1'b0;
    logic [2:0] issue_cnt = '0;
    logic       low_req, drop_evt, raise_evt;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    typedef struct {
        bit    low;
        bit    drop;
        bit    raise;
        string tag;
    } exp_t;
    exp_t exp_q[$];

    always #2 clk = ~clk;

    issue_supply_ctrl u0 (
        .clk        (clk),
        .rst_n      (rst_n),
        .miss_pulse (miss_pulse),
        .ret_pulse  (ret_pulse),
        .issue_cnt  (issue_cnt),
        .low_req    (low_req),
        .drop_evt   (drop_evt),
        .raise_evt  (raise_evt)
    );

    // Driver: apply one cycle of stimulus and queue the expected outputs
    // after the edge that samples it.
    task automatic step(input bit m, input bit r, input int iss,
                        input bit el, input bit ed, input bit er,
                        input string tag);
        exp_t e;
        @(negedge clk);
        miss_pulse = m;
        ret_pulse  = r;
        issue_cnt  = 3'(iss);
        e.low = el; e.drop = ed; e.raise = er; e.tag = tag;
        exp_q.push_back(e);
    endtask

    task automatic hold_low(input int n, input int iss, input bit el,
                            input string tag);
        for (int i = 0; i < n; i++) step(0, 0, iss, el, 0, 0, tag);
    endtask

    // Monitor: pop one expectation after each edge and compare.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            n_chk++;
            if (low_req !== e.low || drop_evt !== e.drop || raise_evt !== e.raise) begin
                n_bad++;
                $display("FAIL %s: got low=%0b drop=%0b raise=%0b exp low=%0b drop=%0b raise=%0b",
                         e.tag, low_req, drop_evt, raise_evt, e.low, e.drop, e.raise);
            end
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        n_chk++;
        if (low_req !== 1'b0 || drop_evt !== 1'b0 || raise_evt !== 1'b0) begin
            n_bad++;
            $display("FAIL reset R2: got low=%0b drop=%0b raise=%0b exp 0 0 0",
                     low_req, drop_evt, raise_evt);
        end
        step(0, 0, 0, 0, 0, 0, "R3 idle without miss");

        // R2: miss then three idle cycles drops the supply
        step(1, 0, 2, 0, 0, 0, "R2 miss");
        step(0, 0, 0, 0, 0, 0, "R2 idle1");
        step(0, 0, 0, 0, 0, 0, "R2 idle2");
        step(0, 0, 0, 1, 1, 0, "R2 idle3 drop");
        step(0, 0, 1, 1, 0, 0, "R2 drop pulse one cycle");
        // R5: lone return raises at once
        step(0, 1, 1, 0, 0, 1, "R5 last return");
        step(0, 0, 1, 0, 0, 0, "R5 raise pulse one cycle");

        // R3: broken runs, window expires, later idle ignored
        step(1, 0, 1, 0, 0, 0, "R3 miss");
        for (int i = 0; i < 10; i++)
            step(0, 0, (i % 3 == 2) ? 1 : 0, 0, 0, 0, "R3 window");
        hold_low(3, 0, 0, "R3 after window");
        // R10: return while high gives no raise
        step(0, 1, 1, 0, 0, 0, "R10 return while high");

        // R4: run reset by an active cycle, miss cycle not counted
        step(1, 0, 0, 0, 0, 0, "R4 miss idle");
        step(0, 0, 0, 0, 0, 0, "R4 w1");
        step(0, 0, 0, 0, 0, 0, "R4 w2");
        step(0, 0, 1, 0, 0, 0, "R4 w3 active");
        step(0, 0, 0, 0, 0, 0, "R4 w4");
        step(0, 0, 0, 0, 0, 0, "R4 w5");
        step(0, 0, 0, 1, 1, 0, "R4 w6 drop");
        // R8: miss while low opens nothing but is counted
        step(1, 0, 0, 1, 0, 0, "R8 miss while low");
        hold_low(4, 0, 1, "R8 no drop pulse");
        // R6: overlapping return, three spread active cycles
        step(0, 1, 0, 1, 0, 0, "R6 return with other outstanding");
        step(0, 0, 1, 1, 0, 0, "R6 a1");
        step(0, 0, 0, 1, 0, 0, "R6 q");
        step(0, 0, 1, 1, 0, 0, "R6 a2");
        step(0, 0, 0, 1, 0, 0, "R6 q");
        step(0, 0, 1, 0, 0, 1, "R6 a3 raise");
        step(0, 1, 0, 0, 0, 0, "R10 drain while high");

        // R7: up window expires, supply stays low
        step(1, 0, 1, 0, 0, 0, "R7 miss");
        hold_low(2, 0, 0, "R7 idle");
        step(0, 0, 0, 1, 1, 0, "R7 drop");
        step(1, 0, 1, 1, 0, 0, "R7 second miss");
        step(0, 1, 0, 1, 0, 0, "R7 return opens window");
        for (int i = 0; i < 10; i++)
            step(0, 0, (i == 0 || i == 8) ? 1 : 0, 1, 0, 0, "R7 window");
        hold_low(3, 1, 1, "R7 active after window");
        step(0, 1, 0, 0, 0, 1, "R5 last return after window");

        // Same-cycle miss and return while low with one in flight
        step(1, 0, 1, 0, 0, 0, "R1 miss");
        hold_low(2, 0, 0, "R1 idle");
        step(0, 0, 0, 1, 1, 0, "R1 drop");
        step(1, 1, 1, 1, 0, 0, "R6 miss and return together");
        step(0, 0, 1, 1, 0, 0, "R6 b1");
        step(0, 0, 1, 1, 0, 0, "R6 b2");
        step(0, 0, 1, 0, 0, 1, "R6 b3 raise");
        step(0, 1, 0, 0, 0, 0, "R1 count held at one");

        // R1: saturation at 15 then at 0
        step(1, 0, 1, 0, 0, 0, "R1 sat miss");
        hold_low(2, 0, 0, "R1 sat idle");
        step(0, 0, 0, 1, 1, 0, "R1 sat drop");
        for (int i = 0; i < 16; i++) step(1, 0, 0, 1, 0, 0, "R1 extra misses");
        for (int i = 0; i < 14; i++) step(0, 1, 0, 1, 0, 0, "R1 returns above one");
        step(0, 1, 0, 0, 0, 1, "R1 fifteenth return raises");
        step(0, 1, 0, 0, 0, 0, "R1 return at zero");
        step(0, 1, 0, 0, 0, 0, "R1 return at zero");
        step(1, 0, 1, 0, 0, 0, "R1 floor miss");
        hold_low(2, 0, 0, "R1 floor idle");
        step(0, 0, 0, 1, 1, 0, "R1 floor drop");
        step(0, 1, 0, 0, 0, 1, "R1 floor single return raises");

        // R9: last return cancels the down window
        step(1, 0, 0, 0, 0, 0, "R9 miss");
        step(0, 0, 0, 0, 0, 0, "R9 w1");
        step(0, 1, 0, 0, 0, 0, "R9 return empties count");
        hold_low(4, 0, 0, "R9 no drop");

        step(0, 0, 0, 0, 0, 0, "tail");
        repeat (3) @(posedge clk);
        #2;
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: got timeout exp completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule